// File: doc/BRIEF.md
# Interrupt Priority Status Register Controller

This block keeps the processor status word. The word holds the current execution priority, a global request enable, a register bank selector and the arithmetic flags. Each cycle the block can take one pending service request. A request is an ordinary interrupt, a cycle-stealing transfer, a hardware trap or a software trap. The block decides whether the request is accepted. Interrupts and transfers must be enabled and must be strictly above the current priority. Traps are always taken.

When a request enters a service routine, the block loads the new priority and bank. At the same time it presents the old status word on a save port, so the surrounding core can push that word to its stack. A cycle-stealing transfer is acknowledged but does not touch the word.

The block also accepts full-word writes from software and flag updates from the datapath. It resolves these against a service entry that happens in the same cycle. All outputs are registered.

Top module: `prio_status_ctrl`

## Requirements
- R1: `psw_o` is laid out as [15:12] priority (0 lowest, 15 highest), [11] global enable, [10] spare, [9:8] bank, [7:5] spare, [4:0] flags (bit4 E, bit3 N, bit2 Z, bit1 V, bit0 C). Every output changes only at the clock edge that samples the inputs causing it.
- R2: An interrupt (kind 2'b00) is accepted only when its level is strictly greater than `psw_o[15:12]`. A request at an equal or lower level gets no acknowledge.
- R3: While `psw_o[11]` is 0, no interrupt and no transfer (kind 2'b01) is acknowledged, whatever its level.
- R4: On an accepted interrupt, `req_ack_o` is 1 for one cycle. In that same cycle `psw_o[15:12]` shows the request level and `psw_o[9:8]` shows the request bank.
- R5: For an accepted interrupt, a hardware trap or a software trap, `save_valid_o` is high for exactly one cycle, together with the new word. In that cycle `save_word_o` equals the word as it was before the update. Transfers and rejected requests never raise `save_valid_o`.
- R6: A transfer (kind 2'b01) is accepted under the same enable and strict-level rule as an interrupt. It is acknowledged without a save, and the status word stays unchanged.
- R7: A hardware trap (kind 2'b10) is always acknowledged, even with the enable at 0. It sets the priority to 15 and the bank to the request bank. After that, no interrupt or transfer is accepted, including one at level 15.
- R8: A software trap (kind 2'b11) is always acknowledged and saves the word. It leaves the priority and bank unchanged, so a higher interrupt can still be accepted afterwards.
- R9: After reset, `psw_o` is 16'h0000 and both `req_ack_o` and `save_valid_o` are 0.
- R10: A software write replaces the whole status word with `sw_wr_data`.
- R11: A flag update replaces `psw_o[4:0]` with `flag_wr_data`. If a software write happens in the same cycle, the software write wins for all bits.
- R12: When a software write and a service entry fall in the same cycle, the entry sets priority and bank. All other bits come from the written data. Acceptance is judged against the word as it was before the write.
- R13: Bank code 2'b01 is stored as written. Acceptance never depends on the bank field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is pending this cycle |
| req_kind | input | 2 | 00 interrupt, 01 transfer, 10 hardware trap, 11 software trap |
| req_level | input | 4 | Priority of the pending request |
| req_bank | input | 2 | Bank tied to the pending request |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 16 | Software write value |
| flag_wr_en | input | 1 | Datapath flag update strobe |
| flag_wr_data | input | 5 | New flag values |
| psw_o | output | 16 | Current status word |
| req_ack_o | output | 1 | Request accepted |
| save_valid_o | output | 1 | Old word is presented for saving |
| save_word_o | output | 16 | Old status word |

## Verification
Every result is due exactly one cycle after the stimulus. The acknowledge, the save strobe and the old word, and the updated status word all appear together after the rising edge that samples the request or write. The driver task applies one set of inputs per cycle on the falling edge. For each cycle it pushes one expected item, computed from a model of the word that the bench keeps. The monitor pops one item just after each following rising edge and compares all four outputs. Expectations therefore line up with the single register stage, and an idle cycle is checked as strictly as an active one.

// File: rtl/psc_pkg.sv
package psc_pkg;
    localparam int WORD_W = 16;
    localparam int LVL_W  = 4;
    localparam int BANK_W = 2;
    localparam int FLAG_W = 5;
    localparam int MISC_W = WORD_W - LVL_W - 1 - 1 - BANK_W - FLAG_W;
    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    typedef enum logic [1:0] {
        REQ_INT    = 2'b00,
        REQ_XFER   = 2'b01,
        REQ_HWTRAP = 2'b10,
        REQ_SWTRAP = 2'b11
    } req_kind_e;

    typedef struct packed {
        logic [LVL_W-1:0]  lvl;
        logic              ien;
        logic              spare;
        logic [BANK_W-1:0] bank;
        logic [MISC_W-1:0] misc;
        logic [FLAG_W-1:0] flags;
    } psw_t;

    typedef struct packed {
        psw_t psw;
        logic ack;
        logic save_vld;
        psw_t save;
    } state_t;
endpackage

// File: rtl/psc_accept.sv
module psc_accept
    import psc_pkg::*;
(
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [LVL_W-1:0] req_level,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             ien,
    output logic             ack,
    output logic             enter,
    output logic             set_lvl,
    output logic             set_bank,
    output logic [LVL_W-1:0] lvl_val
);
    req_kind_e kind;
    logic      above;

    always_comb begin
        kind     = req_kind_e'(req_kind);
        above    = ien && (req_level > cur_lvl);
        ack      = 1'b0;
        enter    = 1'b0;
        set_lvl  = 1'b0;
        set_bank = 1'b0;
        lvl_val  = req_level;
        if (req_valid) begin
            unique case (kind)
                REQ_INT: begin
                    ack      = above;
                    enter    = above;
                    set_lvl  = above;
                    set_bank = above;
                end
                REQ_XFER: begin
                    ack = above;
                end
                REQ_HWTRAP: begin
                    ack      = 1'b1;
                    enter    = 1'b1;
                    set_lvl  = 1'b1;
                    set_bank = 1'b1;
                    lvl_val  = LVL_MAX;
                end
                REQ_SWTRAP: begin
                    ack   = 1'b1;
                    enter = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/psc_merge.sv
module psc_merge
    import psc_pkg::*;
(
    input  psw_t              cur,
    input  logic              sw_we,
    input  logic [WORD_W-1:0] sw_data,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_data,
    output psw_t              base
);
    always_comb begin
        base = cur;
        if (flag_we) base.flags = flag_data;
        if (sw_we)   base = psw_t'(sw_data);
    end
endmodule

// File: rtl/prio_status_ctrl.sv
module prio_status_ctrl
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              sw_wr_en,
    input  logic [WORD_W-1:0] sw_wr_data,
    input  logic              flag_wr_en,
    input  logic [FLAG_W-1:0] flag_wr_data,
    output logic [WORD_W-1:0] psw_o,
    output logic              req_ack_o,
    output logic              save_valid_o,
    output logic [WORD_W-1:0] save_word_o
);
    state_t           st_d, st_q;
    psw_t             base;
    logic             acc_ack, acc_enter, acc_set_lvl, acc_set_bank;
    logic [LVL_W-1:0] acc_lvl;

    psc_accept i_accept (
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_level (req_level),
        .cur_lvl   (st_q.psw.lvl),
        .ien       (st_q.psw.ien),
        .ack       (acc_ack),
        .enter     (acc_enter),
        .set_lvl   (acc_set_lvl),
        .set_bank  (acc_set_bank),
        .lvl_val   (acc_lvl)
    );

    psc_merge i_merge (
        .cur       (st_q.psw),
        .sw_we     (sw_wr_en),
        .sw_data   (sw_wr_data),
        .flag_we   (flag_wr_en),
        .flag_data (flag_wr_data),
        .base      (base)
    );

    always_comb begin
        st_d          = st_q;
        st_d.psw      = base;
        if (acc_set_lvl)  st_d.psw.lvl  = acc_lvl;
        if (acc_set_bank) st_d.psw.bank = req_bank;
        st_d.ack      = acc_ack;
        st_d.save_vld = acc_enter;
        if (acc_enter) st_d.save = st_q.psw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign psw_o        = st_q.psw;
    assign req_ack_o    = st_q.ack;
    assign save_valid_o = st_q.save_vld;
    assign save_word_o  = st_q.save;
endmodule

// File: rtl/psc_checker.sv
module psc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic [3:0]  req_level,
    input logic [15:0] psw_o,
    input logic        req_ack_o,
    input logic        save_valid_o,
    input logic [15:0] save_word_o
);
    p_strict_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b00 && req_level <= psw_o[15:12]) |=> !req_ack_o);

    p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_kind[1] && !psw_o[11]) |=> !req_ack_o);

    p_int_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b00 && psw_o[11] && req_level > psw_o[15:12])
        |=> (req_ack_o && psw_o[15:12] == $past(req_level)));

    p_save_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
        save_valid_o |-> save_word_o == $past(psw_o));

    p_xfer_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b01) |=> (!save_valid_o && $stable(psw_o[15:12])));

    p_hwtrap_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b10) |=> (req_ack_o && save_valid_o && psw_o[15:12] == 4'hF));

    p_swtrap_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b11) |=> (req_ack_o && save_valid_o && $stable(psw_o[15:12])));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!req_ack_o && !save_valid_o));
endmodule

bind prio_status_ctrl psc_checker i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_level    (req_level),
    .psw_o        (psw_o),
    .req_ack_o    (req_ack_o),
    .save_valid_o (save_valid_o),
    .save_word_o  (save_word_o)
);

// File: tb/test_prio_status_ctrl.sv
module test_prio_status_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [3:0]  req_level = '0;
    logic [1:0]  req_bank = '0;
    logic        sw_wr_en = 1'b0;
    logic [15:0] sw_wr_data = '0;
    logic        flag_wr_en = 1'b0;
    logic [4:0]  flag_wr_data = '0;
    logic [15:0] psw_o;
    logic        req_ack_o;
    logic        save_valid_o;
    logic [15:0] save_word_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic        ack;
        logic        sv;
        logic [15:0] sw;
        logic [15:0] psw;
        string       tag;
    } exp_t;
    exp_t exq[$];
    logic [15:0] model = 16'h0000;

    prio_status_ctrl i_prio_status_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_level(req_level), .req_bank(req_bank), .sw_wr_en(sw_wr_en),
        .sw_wr_data(sw_wr_data), .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .psw_o(psw_o), .req_ack_o(req_ack_o), .save_valid_o(save_valid_o),
        .save_word_o(save_word_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] k, input logic [3:0] l, input logic [1:0] b,
                        input logic sw, input logic [15:0] swd, input logic fw, input logic [4:0] fd,
                        input string tag);
        exp_t e;
        logic [15:0] nw;
        logic above, acc, sav;
        @(negedge clk);
        req_valid = v; req_kind = k; req_level = l; req_bank = b;
        sw_wr_en = sw; sw_wr_data = swd; flag_wr_en = fw; flag_wr_data = fd;
        nw = model;
        if (fw) nw[4:0] = fd;
        if (sw) nw = swd;
        above = model[11] && (l > model[15:12]);
        acc = 1'b0; sav = 1'b0;
        if (v) begin
            case (k)
                2'b00: if (above) begin acc = 1'b1; sav = 1'b1; nw[15:12] = l; nw[9:8] = b; end
                2'b01: acc = above;
                2'b10: begin acc = 1'b1; sav = 1'b1; nw[15:12] = 4'hF; nw[9:8] = b; end
                default: begin acc = 1'b1; sav = 1'b1; end
            endcase
        end
        e.ack = acc; e.sv = sav; e.sw = model; e.psw = nw; e.tag = tag;
        exq.push_back(e);
        model = nw;
    endtask

    task automatic idle(input string tag);
        step(1'b0, 2'b00, 4'h0, 2'b00, 1'b0, 16'h0, 1'b0, 5'h0, tag);
    endtask

    task automatic rq(input logic [1:0] k, input logic [3:0] l, input logic [1:0] b, input string tag);
        step(1'b1, k, l, b, 1'b0, 16'h0, 1'b0, 5'h0, tag);
    endtask

    task automatic wr(input logic [15:0] d, input string tag);
        step(1'b0, 2'b00, 4'h0, 2'b00, 1'b1, d, 1'b0, 5'h0, tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exq.size() > 0) begin
                exp_t e;
                e = exq.pop_front();
                chk(e.tag, "ack", {15'h0, req_ack_o}, {15'h0, e.ack});
                chk(e.tag, "save_valid", {15'h0, save_valid_o}, {15'h0, e.sv});
                if (e.sv) chk(e.tag, "save_word", save_word_o, e.sw);
                chk(e.tag, "psw", psw_o, e.psw);
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "psw", psw_o, 16'h0000);
        chk("R9", "ack", {15'h0, req_ack_o}, 16'h0);
        chk("R9", "save_valid", {15'h0, save_valid_o}, 16'h0);
        rst_n = 1'b1;
        idle("R9");
        // R3: enable clear blocks interrupt and transfer
        rq(2'b00, 4'h5, 2'b10, "R3");
        rq(2'b01, 4'h5, 2'b10, "R3");
        // R10: full word write
        wr(16'h0800, "R10");
        // R4 R5: interrupt entry
        rq(2'b00, 4'h3, 2'b10, "R4");
        // R2: equal and lower levels refused
        rq(2'b00, 4'h3, 2'b11, "R2");
        rq(2'b00, 4'h2, 2'b11, "R2");
        // R6: transfer above accepted, no save, word unchanged; equal refused
        rq(2'b01, 4'h7, 2'b11, "R6");
        rq(2'b01, 4'h3, 2'b11, "R6");
        rq(2'b00, 4'h9, 2'b11, "R5");
        // R8: software trap keeps level; higher interrupt still accepted
        rq(2'b11, 4'h1, 2'b00, "R8");
        rq(2'b00, 4'hA, 2'b10, "R8");
        // R11: flag update
        step(1'b0, 2'b00, 4'h0, 2'b00, 1'b0, 16'h0, 1'b1, 5'b10101, "R11");
        // R11: write beats flag update in the same cycle
        step(1'b0, 2'b00, 4'h0, 2'b00, 1'b1, 16'hA812, 1'b1, 5'b01101, "R11");
        // R7: hardware trap to max, then level 15 refused
        rq(2'b10, 4'h2, 2'b00, "R7");
        rq(2'b00, 4'hF, 2'b10, "R7");
        rq(2'b01, 4'hF, 2'b10, "R7");
        // R7: hardware trap with enable cleared
        wr(16'h0000, "R10");
        rq(2'b10, 4'h0, 2'b11, "R7");
        // R12: write and entry in the same cycle
        wr(16'h0800, "R10");
        step(1'b1, 2'b00, 4'h4, 2'b01, 1'b1, 16'h5CE7, 1'b0, 5'h0, "R12");
        // R13: reserved bank stored, acceptance unaffected
        wr(16'h0900, "R13");
        rq(2'b00, 4'h1, 2'b01, "R13");
        idle("R1");
        idle("R1");
        while (exq.size() > 0) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule